// File: doc/BRIEF.md
# MDIO management slave decoder

This block sits on the PHY side of a bit-banged management link. The host toggles a management clock level, a serial data bit and an output-enable bit; the block samples them on the system clock, finds each rising edge of the management clock and shifts one bit per edge into a 32-bit history register. A run of 32 consecutive ones arms a bit counter. Sixteen edges later the block decodes a clause-22 style header (start, opcode, PHY address, register address, turnaround).

A decoded read fetches a 16-bit word from a 32-entry PHY register file and returns it serially, MSB first, on the data-in line, one bit per management clock edge. A decoded write does not touch the register file. Instead, at the last data bit it raises a one-cycle event strobe that carries the PHY address, the register address and the 16 data bits. The register file comes out of reset holding identification values in two entries and zeros everywhere else.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, `mdi_out` is 0 and `wr_stb` is 0.
- R2: The bit shifted in on each management clock rising edge is `mdo_in AND moe_in`, so data bits driven with `moe_in` low are received as zeros.
- R3: Decoding is armed only by 32 consecutive shifted-in ones. A frame preceded by only 31 ones produces neither a write event nor read data.
- R4: A header with start 01, opcode 01 and turnaround 10 (16 header bits sent MSB first as start[1:0], opcode[1:0], PHY[4:0], register[4:0], turnaround[1:0]) followed by 16 data bits produces exactly one write event. The event is raised at the edge of the last data bit and carries those addresses and data.
- R5: A write header (opcode 01) with any turnaround other than 10 is ignored: no write event.
- R6: A header with start 01, opcode 10 and turnaround bit 0 equal to 0 starts a read. Over the next 16 rising edges, `mdi_out` presents the addressed register MSB first, and each bit is updated at its edge.
- R7: A read header whose turnaround bit 0 is 1 is ignored: `mdi_out` keeps its previous value for the whole frame.
- R8: After reset, register 2 holds 0x0022, register 3 holds 0x161A and every other register holds 0.
- R9: An accepted write leaves the register file unchanged.
- R10: `mdi_out` changes only on a management clock rising edge and holds its last driven value otherwise, including after a read completes.
- R11: `wr_stb` is high for exactly one system clock per accepted write.
- R12: Headers with a start field other than 01, or with opcode 00 or 11, are ignored.
- R13: A preamble longer than 32 ones arms decoding from its last 32 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_in | input | 1 | Management clock level from the host |
| mdo_in | input | 1 | Serial data bit from the host |
| moe_in | input | 1 | Host output-enable; when low, the host bit reads as 0 |
| mdi_out | output | 1 | Serial read-data bit returned to the host |
| wr_stb | output | 1 | One-cycle write event strobe |
| wr_phy | output | 5 | PHY address of the write event |
| wr_reg | output | 5 | Register address of the write event |
| wr_data | output | 16 | Data of the write event |

## Verification
The bench targets several corner cases. A 31-one preamble must not arm the decoder; a counter that reloads one edge early would accept the frame and raise a spurious strobe. The two turnaround rules are driven on both sides: a write with turnaround 00 and a read with turnaround 11 must stay silent, while a read with a host-driven 10 must answer, so a design with the rules swapped or unified fails one of them. Data bits sent with the enable low must arrive as zeros, and a read of register 2 after a write to it must still return the reset identification value. A design that stored writes, or that ignored the enable, would show a wrong word.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   typedef enum logic [1:0] {
      MG_IDLE  = 2'd0,
      MG_READ  = 2'd1,
      MG_WRITE = 2'd2
   } mg_state_e;

   localparam logic [1:0] MG_START_CODE = 2'b01;
   localparam logic [1:0] MG_OP_WR      = 2'b01;
   localparam logic [1:0] MG_OP_RD      = 2'b10;
   localparam logic [1:0] MG_TA_WR      = 2'b10;
   localparam int         MG_FIELD_W    = 2;
endpackage

// File: rtl/mdio_mgmt_sampler.sv
module mdio_mgmt_sampler #(
   parameter int SHIFT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mdc_in,
   input  logic               mdo_in,
   input  logic               moe_in,
   output logic               rise,
   output logic               sync_hit,
   output logic [SHIFT_W-1:0] shift_nxt
);
   logic               mdc_last_q;
   logic [SHIFT_W-1:0] shift_q;

   assign rise      = mdc_in & ~mdc_last_q;
   assign shift_nxt = {shift_q[SHIFT_W-2:0], mdo_in & moe_in};
   assign sync_hit  = rise & (&shift_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_last_q <= 1'b0;
         shift_q    <= '0;
      end else begin
         mdc_last_q <= mdc_in;
         if (rise) shift_q <= shift_nxt;
      end
   end
endmodule

// File: rtl/mdio_mgmt_bitcount.sv
module mdio_mgmt_bitcount #(
   parameter int SHIFT_W = 32,
   localparam int CW = $clog2(SHIFT_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          sync_hit,
   output logic [CW-1:0] cnt_eff,
   output logic          cnt_vld
);
   logic [CW-1:0] cnt_q;
   logic          vld_q;

   assign cnt_eff = sync_hit ? CW'(SHIFT_W) : cnt_q;
   assign cnt_vld = sync_hit | vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         vld_q <= 1'b0;
      end else if (rise) begin
         if (cnt_vld && cnt_eff != '0) begin
            cnt_q <= cnt_eff - 1'b1;
            vld_q <= 1'b1;
         end else begin
            cnt_q <= '0;
            vld_q <= 1'b0;
         end
      end
   end

   // R3
   sync_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |=> (vld_q && cnt_q == CW'(SHIFT_W - 1)));
endmodule

// File: rtl/mdio_mgmt_phy_regs.sv
module mdio_mgmt_phy_regs #(
   parameter int              NREG     = 32,
   parameter int              DATA_W   = 16,
   parameter int              ID1_IDX  = 2,
   parameter logic [DATA_W-1:0] ID1_VAL = 16'h0022,
   parameter int              ID2_IDX  = 3,
   parameter logic [DATA_W-1:0] ID2_VAL = 16'h161A,
   localparam int AW = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] mem [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      localparam logic [DATA_W-1:0] RST_V =
         (i == ID1_IDX) ? ID1_VAL : (i == ID2_IDX) ? ID2_VAL : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) mem[i] <= RST_V;
         else        mem[i] <= mem[i];
      end
   end

   assign rd_word = mem[rd_addr];
endmodule

// File: rtl/mdio_mgmt_frame_fsm.sv
module mdio_mgmt_frame_fsm
   import mdio_mgmt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5,
   parameter int CW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic [DATA_W-1:0] frm,
   input  logic [CW-1:0]     cnt_eff,
   input  logic              cnt_vld,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              mdi_out,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_phy,
   output logic [ADDR_W-1:0] wr_reg,
   output logic [DATA_W-1:0] wr_data
);
   localparam int REG_LSB = MG_FIELD_W;
   localparam int PHY_LSB = REG_LSB + ADDR_W;
   localparam int OP_LSB  = PHY_LSB + ADDR_W;
   localparam int ST_LSB  = OP_LSB + MG_FIELD_W;

   mg_state_e         state_q, dec_state, st_after;
   logic [ADDR_W-1:0] phy_q, reg_q;
   logic [DATA_W-1:0] out_sr;
   logic              dec_now, shift_out, frame_end;

   logic [1:0]        fld_st, fld_op, fld_ta;
   logic [ADDR_W-1:0] fld_phy;

   assign fld_st  = frm[ST_LSB +: MG_FIELD_W];
   assign fld_op  = frm[OP_LSB +: MG_FIELD_W];
   assign fld_phy = frm[PHY_LSB +: ADDR_W];
   assign rd_addr = frm[REG_LSB +: ADDR_W];
   assign fld_ta  = frm[0 +: MG_FIELD_W];

   always_comb begin
      if (fld_st == MG_START_CODE && fld_op == MG_OP_WR && fld_ta == MG_TA_WR)
         dec_state = MG_WRITE;
      else if (fld_st == MG_START_CODE && fld_op == MG_OP_RD && !fld_ta[0])
         dec_state = MG_READ;
      else
         dec_state = MG_IDLE;
   end

   assign dec_now   = rise && cnt_vld && (cnt_eff == CW'(DATA_W));
   assign st_after  = dec_now ? dec_state : state_q;
   assign shift_out = rise && cnt_vld && (cnt_eff < CW'(DATA_W)) && (st_after == MG_READ);
   assign frame_end = rise && cnt_vld && (cnt_eff == '0) && (st_after != MG_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MG_IDLE;
         phy_q   <= '0;
         reg_q   <= '0;
         out_sr  <= '0;
         mdi_out <= 1'b0;
         wr_stb  <= 1'b0;
         wr_phy  <= '0;
         wr_reg  <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (dec_now) begin
            state_q <= dec_state;
            if (dec_state != MG_IDLE) begin
               phy_q <= fld_phy;
               reg_q <= rd_addr;
            end
            if (dec_state == MG_READ) out_sr <= rd_word;
         end
         if (shift_out) begin
            mdi_out <= out_sr[DATA_W-1];
            out_sr  <= {out_sr[DATA_W-2:0], 1'b0};
         end
         if (frame_end) begin
            if (st_after == MG_WRITE) begin
               wr_stb  <= 1'b1;
               wr_phy  <= phy_q;
               wr_reg  <= reg_q;
               wr_data <= frm;
            end
            state_q <= MG_IDLE;
         end
      end
   end

   // R11
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // R10
   mdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(mdi_out));
   // R4
   wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ($past(state_q) == MG_WRITE));
   // R6
   rd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MG_READ && $past(state_q) != MG_READ) |-> $past(rise));
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
   parameter int                 DATA_W  = 16,
   parameter int                 ADDR_W  = 5,
   parameter int                 SHIFT_W = 32,
   parameter int                 ID1_IDX = 2,
   parameter logic [DATA_W-1:0]  ID1_VAL = 16'h0022,
   parameter int                 ID2_IDX = 3,
   parameter logic [DATA_W-1:0]  ID2_VAL = 16'h161A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc_in,
   input  logic              mdo_in,
   input  logic              moe_in,
   output logic              mdi_out,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_phy,
   output logic [ADDR_W-1:0] wr_reg,
   output logic [DATA_W-1:0] wr_data
);
   localparam int NREG = 1 << ADDR_W;
   localparam int CW   = $clog2(SHIFT_W + 1);

   if (SHIFT_W != 2 * DATA_W) begin : g_bad_shift
      $error("shift width must be twice the data width");
   end
   if (DATA_W != 3 * mdio_mgmt_pkg::MG_FIELD_W + 2 * ADDR_W) begin : g_bad_hdr
      $error("header fields must fill one data word");
   end
   if (ID1_IDX >= NREG || ID2_IDX >= NREG) begin : g_bad_id
      $error("identification index outside the register file");
   end

   logic               rise, sync_hit, cnt_vld;
   logic [SHIFT_W-1:0] shift_nxt;
   logic [CW-1:0]      cnt_eff;
   logic [ADDR_W-1:0]  rd_addr;
   logic [DATA_W-1:0]  rd_word;

   mdio_mgmt_sampler #(.SHIFT_W(SHIFT_W)) u_sampler (
      .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdo_in(mdo_in),
      .moe_in(moe_in), .rise(rise), .sync_hit(sync_hit), .shift_nxt(shift_nxt)
   );

   mdio_mgmt_bitcount #(.SHIFT_W(SHIFT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .rise(rise), .sync_hit(sync_hit),
      .cnt_eff(cnt_eff), .cnt_vld(cnt_vld)
   );

   mdio_mgmt_phy_regs #(
      .NREG(NREG), .DATA_W(DATA_W), .ID1_IDX(ID1_IDX), .ID1_VAL(ID1_VAL),
      .ID2_IDX(ID2_IDX), .ID2_VAL(ID2_VAL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_word(rd_word)
   );

   mdio_mgmt_frame_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CW(CW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .rise(rise), .frm(shift_nxt[DATA_W-1:0]),
      .cnt_eff(cnt_eff), .cnt_vld(cnt_vld), .rd_word(rd_word),
      .rd_addr(rd_addr), .mdi_out(mdi_out), .wr_stb(wr_stb),
      .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data)
   );

   // R2
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !moe_in) |=> !u_sampler.shift_q[0]);
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdc_in = 1'b0, mdo_in = 1'b0, moe_in = 1'b0;
   logic        mdi_out, wr_stb;
   logic [4:0]  wr_phy, wr_reg;
   logic [15:0] wr_data;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct packed {
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] dat;
   } wr_ev_t;
   wr_ev_t expq[$];
   string  tagq[$];

   always #5 clk = ~clk;

   mdio_mgmt_slave u_dut (
      .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdo_in(mdo_in),
      .moe_in(moe_in), .mdi_out(mdi_out), .wr_stb(wr_stb),
      .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every strobe cycle pops one expected write event
   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         n_chk++;
         if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL R5 unexpected write event actual=%h expected=none",
                     {wr_phy, wr_reg, wr_data});
         end else begin
            wr_ev_t e;
            string  t;
            e = expq.pop_front();
            t = tagq.pop_front();
            if ({wr_phy, wr_reg, wr_data} !== e) begin
               n_fail++;
               $display("FAIL %s write event actual=%h expected=%h",
                        t, {wr_phy, wr_reg, wr_data}, e);
            end
         end
      end
   end

   task automatic tx_bit(input logic b, input logic oe);
      @(negedge clk);
      mdc_in = 1'b0; mdo_in = b; moe_in = oe;
      @(negedge clk);
      mdc_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] rg,
                             input logic [1:0] ta, input logic ta_oe,
                             input logic [15:0] dat, input logic dat_oe,
                             input logic rd_chk, input logic [15:0] rd_exp,
                             input logic hold_chk, input string tag);
      logic [13:0] hdr;
      logic        hold_v;
      hold_v = mdi_out;
      hdr = {st, op, phy, rg};
      for (int i = 0; i < pre; i++) tx_bit(1'b1, 1'b1);
      for (int i = 13; i >= 0; i--) tx_bit(hdr[i], 1'b1);
      for (int i = 1; i >= 0; i--) tx_bit(ta[i], ta_oe);
      for (int i = 15; i >= 0; i--) begin
         tx_bit(dat[i], dat_oe);
         if (rd_chk)   check(tag, {31'd0, mdi_out}, {31'd0, rd_exp[i]});
         if (hold_chk) check(tag, {31'd0, mdi_out}, {31'd0, hold_v});
      end
   endtask

   task automatic expect_wr(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] dat, input string tag);
      expq.push_back({phy, rg, dat});
      tagq.push_back(tag);
   endtask

   task automatic do_read(input logic [4:0] rg, input logic [15:0] exp, input string tag);
      send_frame(32, 2'b01, 2'b10, 5'h01, rg, 2'b00, 1'b0, 16'h0000, 1'b0,
                 1'b1, exp, 1'b0, tag);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {31'd0, mdi_out}, 32'd0);
      check("R1", {31'd0, wr_stb}, 32'd0);

      // R8 reset defaults, R6 read with released turnaround
      do_read(5'd3, 16'h161A, "R8");
      do_read(5'd2, 16'h0022, "R8");
      do_read(5'd5, 16'h0000, "R8");
      do_read(5'd31, 16'h0000, "R8");

      // R6 read with host-driven turnaround 10 is accepted
      send_frame(32, 2'b01, 2'b10, 5'h07, 5'd3, 2'b10, 1'b1, 16'h0000, 1'b0,
                 1'b1, 16'h161A, 1'b0, "R6");

      // R10 data-in holds after a read while idle bits toggle the clock
      for (int i = 0; i < 5; i++) begin
         tx_bit(1'b1, 1'b0);
         check("R10", {31'd0, mdi_out}, 32'd0);
      end

      // R4 / R11 accepted write
      expect_wr(5'h0A, 5'h11, 16'hA5C3, "R4");
      send_frame(32, 2'b01, 2'b01, 5'h0A, 5'h11, 2'b10, 1'b1, 16'hA5C3, 1'b1,
                 1'b0, 16'h0, 1'b0, "R4");
      repeat (3) @(negedge clk);
      check("R11", expq.size(), 0);

      // R2 data bits with enable low arrive as zeros
      expect_wr(5'h15, 5'h02, 16'h0000, "R2");
      send_frame(32, 2'b01, 2'b01, 5'h15, 5'h02, 2'b10, 1'b1, 16'hFFFF, 1'b0,
                 1'b0, 16'h0, 1'b0, "R2");

      // R9 write to register 2 leaves it unchanged
      expect_wr(5'h01, 5'h02, 16'hBEEF, "R9");
      send_frame(32, 2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 1'b1, 16'hBEEF, 1'b1,
                 1'b0, 16'h0, 1'b0, "R9");
      do_read(5'd2, 16'h0022, "R9");

      // R13 long preamble
      expect_wr(5'h03, 5'h07, 16'hFFFF, "R13");
      send_frame(40, 2'b01, 2'b01, 5'h03, 5'h07, 2'b10, 1'b1, 16'hFFFF, 1'b1,
                 1'b0, 16'h0, 1'b0, "R13");

      // R5 write with turnaround 00 and 11 ignored
      send_frame(32, 2'b01, 2'b01, 5'h04, 5'h04, 2'b00, 1'b1, 16'h1234, 1'b1,
                 1'b0, 16'h0, 1'b1, "R5");
      send_frame(32, 2'b01, 2'b01, 5'h04, 5'h04, 2'b11, 1'b1, 16'h1234, 1'b1,
                 1'b0, 16'h0, 1'b1, "R5");

      // R7 read with turnaround low bit 1 ignored
      send_frame(32, 2'b01, 2'b10, 5'h01, 5'd3, 2'b11, 1'b1, 16'h0000, 1'b0,
                 1'b0, 16'h0, 1'b1, "R7");

      // R12 bad opcode / bad start
      send_frame(32, 2'b01, 2'b11, 5'h01, 5'd3, 2'b10, 1'b1, 16'h5555, 1'b1,
                 1'b0, 16'h0, 1'b1, "R12");
      send_frame(32, 2'b00, 2'b01, 5'h01, 5'd3, 2'b10, 1'b1, 16'h5555, 1'b1,
                 1'b0, 16'h0, 1'b1, "R12");
      send_frame(32, 2'b01, 2'b00, 5'h01, 5'd3, 2'b10, 1'b1, 16'h5555, 1'b1,
                 1'b0, 16'h0, 1'b1, "R12");

      // R3 only 31 ones: no write event
      tx_bit(1'b0, 1'b0);
      send_frame(31, 2'b01, 2'b01, 5'h09, 5'h09, 2'b10, 1'b1, 16'h0F0F, 1'b1,
                 1'b0, 16'h0, 1'b0, "R3");
      // R3 only 31 ones: no read data
      tx_bit(1'b0, 1'b0);
      send_frame(31, 2'b01, 2'b10, 5'h01, 5'd3, 2'b00, 1'b0, 16'h0000, 1'b0,
                 1'b0, 16'h0, 1'b1, "R3");

      repeat (5) @(negedge clk);
      check("R4", expq.size(), 0);
      finish_run();
   end
endmodule